// File: doc/BRIEF.md
# Key Matrix Wake Controller

This block serves a key matrix of four rows and three columns. Rows are outputs. Columns are inputs that the board pulls low. Between key events the controller sits in one of two wait states and only watches the columns for an edge, so nothing is scanned while no key changes. An edge wakes it. It then waits a debounce interval, counted in pulses of a slow `tick` input, and walks the rows to find the key. A newly confirmed key is reported as a one-cycle `key_valid` strobe together with a 4-bit code.

States: `S_WAIT_PRESS` (all rows high, asleep), `S_DEB_PRESS` (debounce after a rising column edge), `S_SCAN_PRESS` (row walk after a press), `S_WAIT_REL` (only the held key's row high, asleep), `S_DEB_REL` (debounce after a falling column edge) and `S_SCAN_REL` (row walk after a release).

Transitions:
- *wake-press*: a column rises in `S_WAIT_PRESS` and the block enters `S_DEB_PRESS`.
- *settle*: the debounce count completes, so `S_DEB_PRESS` goes to `S_SCAN_PRESS` and `S_DEB_REL` goes to `S_SCAN_REL`.
- *found*: a scan hits a key and the block enters `S_WAIT_REL`. Only the hit from `S_SCAN_PRESS` strobes.
- *empty*: a scan passes the last row with no hit and the block returns to `S_WAIT_PRESS`.
- *wake-release*: a column falls in `S_WAIT_REL` and the block enters `S_DEB_REL`.

Top module: `keypad_wake_ctrl`

## Requirements
- R1: After reset, `row_drv` is 4'b1111, `awake` is 0, `key_valid` is 0 and `key_code` is 0.
- R2: While waiting for a press, all rows are driven high and `awake` is 0. A rising edge on any column bit sets `awake` to 1 within a few clocks.
- R3: After a wake, the block counts DEB_TICKS pulses of `tick` (default 20) before it starts to scan. Column changes during this interval are ignored, and the row drive is left unchanged.
- R4: The scan drives `row_drv` one-hot, with bit 0 (row 0) first and bit 3 last. Each row is held for one tick, and the columns are sampled on that tick. The first hit in row-major order wins: lowest row first, then lowest column bit.
- R5: A key found by a press scan sets `key_code` = row*3 + column, where the row is the `row_drv` bit and the column is the `col_in` bit. `key_valid` is pulsed for exactly one clock cycle.
- R6: While waiting for a release, only the held key's row is high, the other rows are low, and `awake` is 0. Pressing keys in other rows has no effect. A falling edge on any column starts a release debounce.
- R7: After a release debounce the block scans again. If a key is still held, it returns to wait-for-release driving that key's row, with no strobe. If no key is held, it returns to wait-for-press, with no strobe.
- R8: A press that is gone by the time of the scan returns the block to wait-for-press with no strobe.
- R9: `key_code` keeps its value between strobes.
- R10: `awake` is 1 exactly in the debounce and scan states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow timing pulse for debounce and scan steps |
| col_in | input | 3 | Column lines, pulled low off chip |
| row_drv | output | 4 | Row drive levels |
| key_valid | output | 1 | One-cycle strobe for a newly confirmed press |
| key_code | output | 4 | Code of the last confirmed press |
| awake | output | 1 | High while debouncing or scanning |

## Verification
On every cycle, the assertions check the following:
- the strobe is one cycle wide, comes only out of a press scan, and carries a code below twelve;
- the code does not change without a strobe;
- the row drive is always either all-high or one-hot, and it stays still while the block sleeps;
- the debounce counter stays inside its window.

Only the bench scenarios can show the rest:
- the actual code values;
- the row-major choice when two keys are held;
- the row walk order;
- the length of the debounce interval;
- that keys in undriven rows are ignored;
- that a rescan after a partial release moves the held row without a strobe;
- that a short press is dropped.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

    typedef enum logic [2:0] {
        S_WAIT_PRESS = 3'd0,
        S_DEB_PRESS  = 3'd1,
        S_SCAN_PRESS = 3'd2,
        S_WAIT_REL   = 3'd3,
        S_DEB_REL    = 3'd4,
        S_SCAN_REL   = 3'd5
    } kp_state_t;

endpackage

// File: rtl/keypad_col_sync.sv
module keypad_col_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] col_raw,
    output logic [WIDTH-1:0] col_sync,
    output logic             rise_any,
    output logic             fall_any
);

    logic [WIDTH-1:0] pipe [STAGES];
    logic [WIDTH-1:0] col_last;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= col_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign col_sync = pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) col_last <= '0;
        else        col_last <= col_sync;
    end

    assign rise_any = |(col_sync & ~col_last);
    assign fall_any = |(~col_sync & col_last);

endmodule

// File: rtl/keypad_debounce.sv
module keypad_debounce #(
    parameter int DEB_TICKS = 20,
    localparam int CNT_W = $clog2(DEB_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);

    logic [CNT_W-1:0] cnt;

    assign done = run && tick && (cnt == CNT_W'(DEB_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= done ? '0 : cnt + 1'b1;
        end
    end

    AST_DEB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < DEB_TICKS); // R3

    AST_DEB_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(cnt)); // R3

endmodule

// File: rtl/keypad_first_hit.sv
module keypad_first_hit #(
    parameter int WIDTH = 3,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/keypad_wake_ctrl.sv
module keypad_wake_ctrl
    import keypad_pkg::*;
#(
    parameter int ROWS        = 4,
    parameter int COLS        = 3,
    parameter int DEB_TICKS   = 20,
    parameter int SYNC_STAGES = 2,
    localparam int CODE_W = $clog2(ROWS * COLS),
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [COLS-1:0]   col_in,
    output logic [ROWS-1:0]   row_drv,
    output logic              key_valid,
    output logic [CODE_W-1:0] key_code,
    output logic              awake
);

    kp_state_t state, state_nx;

    logic [COLS-1:0]   col_sync;
    logic              rise_any, fall_any;
    logic              deb_clear, deb_run, deb_done;
    logic              hit;
    logic [COL_W-1:0]  hit_col;
    logic [ROW_W-1:0]  scan_row, held_row;
    logic              scanning, scan_step, last_row;
    logic [CODE_W-1:0] code_now;

    keypad_col_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_raw  (col_in),
        .col_sync (col_sync),
        .rise_any (rise_any),
        .fall_any (fall_any)
    );

    keypad_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (deb_clear),
        .run   (deb_run),
        .tick  (tick),
        .done  (deb_done)
    );

    keypad_first_hit #(.WIDTH(COLS)) u_hit (
        .vec (col_sync),
        .hit (hit),
        .idx (hit_col)
    );

    assign scanning  = (state == S_SCAN_PRESS) || (state == S_SCAN_REL);
    assign scan_step = scanning && tick;
    assign last_row  = (scan_row == ROW_W'(ROWS - 1));
    assign deb_run   = (state == S_DEB_PRESS) || (state == S_DEB_REL);
    assign deb_clear = ((state == S_WAIT_PRESS) && rise_any) ||
                       ((state == S_WAIT_REL) && fall_any);
    assign code_now  = CODE_W'(scan_row) * CODE_W'(COLS) + CODE_W'(hit_col);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_WAIT_PRESS;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            S_WAIT_PRESS: if (rise_any) state_nx = S_DEB_PRESS;
            S_DEB_PRESS:  if (deb_done) state_nx = S_SCAN_PRESS;
            S_SCAN_PRESS: if (tick) begin
                              if (hit)           state_nx = S_WAIT_REL;
                              else if (last_row) state_nx = S_WAIT_PRESS;
                          end
            S_WAIT_REL:   if (fall_any) state_nx = S_DEB_REL;
            S_DEB_REL:    if (deb_done) state_nx = S_SCAN_REL;
            S_SCAN_REL:   if (tick) begin
                              if (hit)           state_nx = S_WAIT_REL;
                              else if (last_row) state_nx = S_WAIT_PRESS;
                          end
            default:      state_nx = S_WAIT_PRESS;
        endcase
    end

    // scan row walk, held row, code and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_row  <= '0;
            held_row  <= '0;
            key_code  <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            if (deb_done) begin
                scan_row <= '0;
            end else if (scan_step) begin
                if (hit) begin
                    held_row <= scan_row;
                    if (state == S_SCAN_PRESS) begin
                        key_code  <= code_now;
                        key_valid <= 1'b1;
                    end
                end else if (!last_row) begin
                    scan_row <= scan_row + 1'b1;
                end
            end
        end
    end

    // outputs from state
    always_comb begin
        row_drv = '0;
        awake   = 1'b0;
        unique case (state)
            S_WAIT_PRESS: row_drv = '1;
            S_DEB_PRESS: begin
                row_drv = '1;
                awake   = 1'b1;
            end
            S_SCAN_PRESS, S_SCAN_REL: begin
                row_drv[scan_row] = 1'b1;
                awake = 1'b1;
            end
            S_WAIT_REL: row_drv[held_row] = 1'b1;
            S_DEB_REL: begin
                row_drv[held_row] = 1'b1;
                awake = 1'b1;
            end
            default: row_drv = '1;
        endcase
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid); // R5

    AST_STROBE_FROM_PRESS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> ($past(state) == S_SCAN_PRESS)); // R7

    AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (int'(key_code) < ROWS * COLS)); // R5

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code)); // R9

    AST_ROWS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(row_drv) || (row_drv == '1))); // R4

    AST_SLEEP_ROWS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake && !$past(awake)) |-> $stable(row_drv)); // R6

    AST_ROW_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !tick) |=> $stable(row_drv)); // R4

endmodule

// File: tb/keypad_wake_ctrl_tb.sv
module keypad_wake_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  col_in;
    logic [3:0]  row_drv;
    logic        key_valid;
    logic [3:0]  key_code;
    logic        awake;
    logic [11:0] keys = '0;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int wide = 0;
    int last_code = 0;
    logic kv_prev = 1'b0;
    logic rec_on = 1'b0;
    logic [19:0] rec_log = '0;
    logic [3:0]  rec_last = '0;

    always #4 clk = ~clk;

    keypad_wake_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .col_in    (col_in),
        .row_drv   (row_drv),
        .key_valid (key_valid),
        .key_code  (key_code),
        .awake     (awake)
    );

    // key matrix model: a pressed key connects its row to its column
    always_comb begin
        col_in = '0;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 3; c++)
                if (keys[r*3+c] && row_drv[r]) col_in[c] = 1'b1;
    end

    initial begin
        forever begin
            repeat (7) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (key_valid) begin
            strobes++;
            last_code = int'(key_code);
            if (kv_prev) wide++;
        end
        kv_prev = key_valid;
        if (rec_on && awake && row_drv != rec_last) begin
            rec_log  = {rec_log[15:0], row_drv};
            rec_last = row_drv;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 8) @(negedge clk);
    endtask

    // stimulus vectors: [7:6] row, [5:4] column, [3:0] expected code
    localparam logic [7:0] VEC [6] = '{
        {2'd0, 2'd0, 4'd0},
        {2'd0, 2'd2, 4'd2},
        {2'd1, 2'd1, 4'd4},
        {2'd2, 2'd0, 4'd6},
        {2'd3, 2'd1, 4'd10},
        {2'd3, 2'd2, 4'd11}
    };

    initial begin
        int s0;
        repeat (5) @(negedge clk);
        chk("R1 rows in reset", int'(row_drv), 15);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rows", int'(row_drv), 15);
        chk("R1 awake", int'(awake), 0);
        chk("R1 strobe", int'(key_valid), 0);
        chk("R1 code", int'(key_code), 0);

        // table walk: press, confirm, release
        for (int i = 0; i < 6; i++) begin
            int row = int'(VEC[i][7:6]);
            int col = int'(VEC[i][5:4]);
            int exp = int'(VEC[i][3:0]);
            s0 = strobes;
            keys[row*3+col] = 1'b1;
            repeat (5) @(negedge clk);
            chk("R2 awake after press", int'(awake), 1);
            wait_ticks(30);
            chk("R5 one strobe", strobes, s0 + 1);
            chk("R5 code", last_code, exp);
            chk("R6 single row held", int'(row_drv), 1 << row);
            chk("R6 asleep while held", int'(awake), 0);
            keys[row*3+col] = 1'b0;
            wait_ticks(30);
            chk("R7 back to all rows", int'(row_drv), 15);
            chk("R7 no strobe on release", strobes, s0 + 1);
            chk("R9 code kept", int'(key_code), exp);
            chk("R2 asleep when idle", int'(awake), 0);
        end

        // R3: debounce length, then R6/R7 other-row key and partial release
        s0 = strobes;
        keys[1*3+2] = 1'b1;
        repeat (5) @(negedge clk);
        wait_ticks(17);
        chk("R3 still debouncing", int'(awake), 1);
        chk("R3 rows unchanged during debounce", int'(row_drv), 15);
        chk("R3 no early strobe", strobes, s0);
        wait_ticks(13);
        chk("R5 code row1 col2", last_code, 5);
        keys[2*3+0] = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 other row ignored awake", int'(awake), 0);
        chk("R6 other row ignored rows", int'(row_drv), 2);
        keys[1*3+2] = 1'b0;
        wait_ticks(30);
        chk("R7 rescan moves to held row", int'(row_drv), 4);
        chk("R7 no strobe on rescan", strobes, s0 + 1);
        chk("R9 code after rescan", int'(key_code), 5);
        keys = '0;
        wait_ticks(30);
        chk("R7 idle after all released", int'(row_drv), 15);

        // R8: short press
        s0 = strobes;
        keys[0*3+1] = 1'b1;
        wait_ticks(5);
        keys[0*3+1] = 1'b0;
        wait_ticks(30);
        chk("R8 no strobe", strobes, s0);
        chk("R8 back to wait-press", int'(row_drv), 15);
        chk("R10 asleep", int'(awake), 0);

        // R4: two keys in different rows, then two in one row
        s0 = strobes;
        keys[2*3+1] = 1'b1;
        keys[1*3+2] = 1'b1;
        wait_ticks(30);
        chk("R4 lowest row wins", last_code, 5);
        chk("R4 held row", int'(row_drv), 2);
        keys = '0;
        wait_ticks(30);
        keys[3*3+2] = 1'b1;
        keys[3*3+1] = 1'b1;
        wait_ticks(30);
        chk("R4 lowest column wins", last_code, 10);
        chk("R4 strobes", strobes, s0 + 2);
        keys = '0;
        wait_ticks(30);

        // R4: row walk order seen while awake
        rec_last = 4'd0;
        rec_log  = '0;
        rec_on   = 1'b1;
        keys[3*3+0] = 1'b1;
        wait_ticks(30);
        rec_on = 1'b0;
        chk("R4 walk order", int'(rec_log), 32'h000F1248);
        chk("R5 code row3 col0", last_code, 9);
        keys = '0;
        wait_ticks(30);
        chk("R5 strobe width", wide, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule